// File: doc/BRIEF.md
# Quad Two-Rank Converter Code Register File

This block is the digital front end for four 12-bit voltage-output converters. A host reaches it through a parallel port with an active-low select, a 2-bit channel address, separate active-low write and read strobes and a shared 12-bit bidirectional data bus. Each channel holds two registers. The host fills the input (first) rank one channel at a time. A global update strobe then copies every input register into the output (second) rank at once, so that all four converter codes change together. The output rank drives the converter code outputs. It is also the rank the host reads back, so software can confirm the code that actually sits at each converter.

All port activity is brought into the system clock domain through a two-flop synchronizer. A write takes effect when the synchronized write strobe rises with the chip selected. The data and address are sampled in the cycle that edge is detected. While the update line stays high with the chip selected, the output rank follows the input rank. A write in that state reaches the converter code at the same clock edge that loads the input register. An asynchronous active-low reset puts the offset-binary zero code 12'h800 into both ranks of every channel.

Top module: `qdac_regfile`

## Requirements
- R1: After reset every channel's converter code reads 12'h800 and the data bus is not driven by the block.
- R2: With select low, a rising write strobe loads the bus value into the input register of the channel given by the address (00 is channel 0, 01 channel 1, 10 channel 2, 11 channel 3). The converter codes do not change while the update line is low.
- R3: A write strobe with select high leaves every input register unchanged. A later update therefore shows the old value.
- R4: An update pulse with select low copies all four input registers into their output registers in the same clock cycle.
- R5: While the update line is held high with select low, the output rank follows the input rank. A write then reaches the converter code in the same cycle as the input register.
- R6: An update pulse with select high changes no converter code.
- R7: With select low and read strobe low, the bus carries the addressed channel's output register (channel k at bits k*12 of the code output), not its input register.
- R8: The block releases the bus whenever the read strobe is high or select is high, including a low read strobe with select high.
- R9: Taking reset low mid-operation forces all converter codes to 12'h800 at once, without a clock edge, and also clears the input rank, so that a following update still yields 12'h800.
- R10: The bus is driven by the second rising clock edge after the read strobe falls, and released by the second rising clock edge after it rises (16 ns at 125 MHz, inside the 40 ns and 30 ns limits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to offset-binary zero |
| sel_n | input | 1 | Active-low chip select |
| addr | input | 2 | Channel address |
| wr_n | input | 1 | Active-low write strobe, acts on its rising edge |
| rd_n | input | 1 | Active-low readback strobe |
| upd | input | 1 | Second-rank update, level-sensitive while high |
| data_io | inout | 12 | Bidirectional data bus |
| dac_code | output | 48 | Four converter codes, channel k at bits [k*12 +: 12] |

## Verification
The hardest case to reach is the coincidence of a write edge and an active update. In it the new value must bypass the input register and land in the output rank in the same cycle. The bench reaches it by holding the update line high with select low and then running a full write strobe sequence, so the two events meet in the synchronized domain. Separating the input rank from the output rank is also indirect, since the input rank is never visible at the ports. The stimulus writes values, reads back the unchanged output rank, and only then pulses update. For the reset case it pulses update after reset, which shows the input rank was cleared.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Host-port control lines carried through the synchronizer as one bundle.
   typedef struct packed {
      logic sel_n;
      logic wr_n;
      logic rd_n;
      logic upd;
   } qdac_ctl_t;

   localparam int QDAC_CTL_W = $bits(qdac_ctl_t);

   // Idle level of every control line, used as synchronizer reset value.
   localparam qdac_ctl_t QDAC_CTL_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, upd: 1'b0};

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_chk_stages
      $error("qdac_sync needs at least two stages");
   end
   if (W < 1) begin : g_chk_w
      $error("qdac_sync width must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int DW = 12,
   parameter logic [DW-1:0] RST_CODE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          xfer_en,
   output logic [DW-1:0] rank1_q,
   output logic [DW-1:0] rank2_q
);

   // Value the first rank holds after this edge: a same-cycle write wins,
   // so a transfer in that cycle carries the fresh value.
   logic [DW-1:0] rank1_nxt;
   assign rank1_nxt = wr_en ? wr_data : rank1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rank1_q <= RST_CODE;
         rank2_q <= RST_CODE;
      end else begin
         rank1_q <= rank1_nxt;
         if (xfer_en) begin
            rank2_q <= rank1_nxt;
         end
      end
   end

endmodule

// File: rtl/qdac_rdport.sv
module qdac_rdport #(
   parameter int DW = 12,
   parameter int NCH = 4,
   localparam int AW = $clog2(NCH)
) (
   input  logic [NCH*DW-1:0] rank2_flat,
   input  logic [AW-1:0]     addr,
   output logic [DW-1:0]     rd_data
);

   logic [DW-1:0] slot [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_slot
      assign slot[c] = rank2_flat[c*DW +: DW];
   end

   assign rd_data = slot[addr];

endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile #(
   parameter int DW = 12,
   parameter int NCH = 4,
   parameter int SYNC_STAGES = 2,
   localparam int AW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic [AW-1:0]     addr,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              upd,
   inout  wire  [DW-1:0]     data_io,
   output logic [NCH*DW-1:0] dac_code
);

   import qdac_pkg::*;

   localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

   if (DW < 2) begin : g_chk_dw
      $error("qdac_regfile data width must be at least 2");
   end
   if (NCH < 2 || (1 << AW) != NCH) begin : g_chk_nch
      $error("qdac_regfile channel count must be a power of two, at least 2");
   end

   qdac_ctl_t ctl_raw;
   qdac_ctl_t ctl_s;
   logic      wr_prev;
   logic      sel_s;
   logic      xfer_s;
   logic      wr_edge;
   logic      bus_oe;
   logic [DW-1:0] rd_data;
   logic [NCH*DW-1:0] rank1_flat;

   assign ctl_raw = '{sel_n: sel_n, wr_n: wr_n, rd_n: rd_n, upd: upd};

   qdac_sync #(
      .W      (QDAC_CTL_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(QDAC_CTL_IDLE)
   ) ctl_sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ctl_raw),
      .q    (ctl_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= QDAC_CTL_IDLE.wr_n;
      end else begin
         wr_prev <= ctl_s.wr_n;
      end
   end

   assign sel_s   = ~ctl_s.sel_n;
   assign xfer_s  = sel_s & ctl_s.upd;
   assign wr_edge = sel_s & ctl_s.wr_n & ~wr_prev;
   assign bus_oe  = sel_s & ~ctl_s.rd_n;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic ch_wr;
      assign ch_wr = wr_edge && (addr == AW'(c));

      qdac_chan #(
         .DW      (DW),
         .RST_CODE(MID_CODE)
      ) chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (ch_wr),
         .wr_data(data_io),
         .xfer_en(xfer_s),
         .rank1_q(rank1_flat[c*DW +: DW]),
         .rank2_q(dac_code[c*DW +: DW])
      );
   end

   qdac_rdport #(
      .DW (DW),
      .NCH(NCH)
   ) rdport_i (
      .rank2_flat(dac_code),
      .addr      (addr),
      .rd_data   (rd_data)
   );

   assign data_io = bus_oe ? rd_data : {DW{1'bz}};

endmodule

// File: rtl/qdac_regfile_chk.sv
module qdac_regfile_chk #(
   parameter int DW = 12,
   parameter int NCH = 4,
   localparam int AW = $clog2(NCH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [AW-1:0]     addr,
   input logic [DW-1:0]     data_io,
   input logic [NCH*DW-1:0] dac_code,
   input logic [NCH*DW-1:0] rank1_flat,
   input logic              sel_s,
   input logic              xfer_s,
   input logic              wr_edge,
   input logic              bus_oe
);

   localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

   logic          wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         wr_q   <= wr_edge;
         addr_q <= addr;
         data_q <= data_io;
      end
   end

   // R1: first cycle out of reset still shows mid-scale on every channel
   p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> dac_code == {NCH{MID_CODE}});

   // R2: a detected write lands in the addressed input register
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> rank1_flat[addr_q*DW +: DW] == data_q);

   // R2: without an active update the converter codes hold
   p_hold_no_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_s |=> $stable(dac_code));

   // R3: a deselected port leaves the input rank alone
   p_sel_off_rank1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> $stable(rank1_flat));

   // R4: a transfer without a write copies the whole input rank
   p_xfer_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_s && !wr_edge) |=> dac_code == $past(rank1_flat));

   // R6: a deselected port leaves the converter codes alone
   p_sel_off_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> $stable(dac_code));

   // R7: while driving, the bus carries the addressed output register
   p_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> data_io == dac_code[addr*DW +: DW]);

endmodule

bind qdac_regfile qdac_regfile_chk #(
   .DW (DW),
   .NCH(NCH)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .data_io   (data_io),
   .dac_code  (dac_code),
   .rank1_flat(rank1_flat),
   .sel_s     (sel_s),
   .xfer_s    (xfer_s),
   .wr_edge   (wr_edge),
   .bus_oe    (bus_oe)
);

// File: tb/qdac_regfile_tb.sv
`timescale 1ns/1ps
module qdac_regfile_tb_top;

   localparam int DW  = 12;
   localparam int NCH = 4;
   localparam int AW  = 2;
   localparam logic [DW-1:0] MID  = 12'h800;
   localparam logic [DW-1:0] IDLE = 12'hFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic wr_n = 1'b1;
   logic rd_n = 1'b1;
   logic upd = 1'b0;
   logic tb_oe = 1'b0;
   logic [DW-1:0] tb_data = '0;
   wire  [DW-1:0] data_io;
   logic [NCH*DW-1:0] dac_code;

   int tests = 0;
   int fails = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   assign data_io = tb_oe ? tb_data : {DW{1'bz}};
   for (genvar b = 0; b < DW; b++) begin : g_pu
      pullup (data_io[b]);
   end

   qdac_regfile dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (sel_n),
      .addr    (addr),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .upd     (upd),
      .data_io (data_io),
      .dac_code(dac_code)
   );

   // Behavioural reference: input history, two ranks, bus enable.
   logic h_sel[4], h_wr[4], h_rd[4], h_upd[4];
   logic [DW-1:0] m_r1[NCH];
   logic [DW-1:0] m_r2[NCH];
   logic m_oe;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            h_sel[i] = 1'b1; h_wr[i] = 1'b1; h_rd[i] = 1'b1; h_upd[i] = 1'b0;
         end
         for (int c = 0; c < NCH; c++) begin
            m_r1[c] = MID; m_r2[c] = MID;
         end
         m_oe = 1'b0;
      end else begin
         for (int i = 3; i > 0; i--) begin
            h_sel[i] = h_sel[i-1]; h_wr[i] = h_wr[i-1];
            h_rd[i] = h_rd[i-1]; h_upd[i] = h_upd[i-1];
         end
         h_sel[0] = sel_n; h_wr[0] = wr_n; h_rd[0] = rd_n; h_upd[0] = upd;
         if (!h_sel[2] && h_wr[2] && !h_wr[3]) m_r1[addr] = tb_data;
         if (!h_sel[2] && h_upd[2]) begin
            for (int c = 0; c < NCH; c++) m_r2[c] = m_r1[c];
         end
         m_oe = !h_sel[1] && !h_rd[1];
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the reference, away from the edge.
   always begin
      @(posedge clk);
      #2;
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            chk(cur_req, $sformatf("cycle code ch%0d", c), dac_code[c*DW +: DW], m_r2[c]);
         end
         chk(cur_req, "cycle bus", data_io,
             tb_oe ? tb_data : (m_oe ? m_r2[addr] : IDLE));
      end
   end

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic s_n, input int ch,
                           input logic [DW-1:0] v, input bit keep_sel);
      @(negedge clk);
      sel_n = s_n; addr = AW'(ch); tb_data = v; tb_oe = 1'b1;
      wait_neg(2); wr_n = 1'b0;
      wait_neg(2); wr_n = 1'b1;
      wait_neg(4); if (!keep_sel) sel_n = 1'b1; tb_oe = 1'b0;
      wait_neg(3);
   endtask

   task automatic do_update(input logic s_n);
      @(negedge clk);
      sel_n = s_n;
      wait_neg(2); upd = 1'b1;
      wait_neg(2); upd = 1'b0;
      wait_neg(4); sel_n = 1'b1;
      wait_neg(3);
   endtask

   task automatic do_read(input int ch, input logic [DW-1:0] exp, input string req);
      @(negedge clk);
      sel_n = 1'b0; addr = AW'(ch); rd_n = 1'b0;
      wait_neg(3);
      chk(req, $sformatf("readback ch%0d", ch), data_io, exp);
      rd_n = 1'b1;
      wait_neg(3);
      chk(req, "bus released after read", data_io, IDLE);
      sel_n = 1'b1;
      wait_neg(1);
   endtask

   task automatic chk_codes(input string req, input logic [DW-1:0] e0,
                            input logic [DW-1:0] e1, input logic [DW-1:0] e2,
                            input logic [DW-1:0] e3);
      chk(req, "code ch0", dac_code[0*DW +: DW], e0);
      chk(req, "code ch1", dac_code[1*DW +: DW], e1);
      chk(req, "code ch2", dac_code[2*DW +: DW], e2);
      chk(req, "code ch3", dac_code[3*DW +: DW], e3);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      wait_neg(4);
      rst_n = 1'b1;
      wait_neg(3);
      chk_codes("R1", MID, MID, MID, MID);
      chk("R1", "bus idle after reset", data_io, IDLE);

      // R2: sequential first-rank loads, codes held
      cur_req = "R2";
      do_write(1'b0, 0, 12'h123, 1'b0);
      do_write(1'b0, 1, 12'h456, 1'b0);
      do_write(1'b0, 2, 12'h789, 1'b0);
      do_write(1'b0, 3, 12'hABC, 1'b0);
      chk_codes("R2", MID, MID, MID, MID);

      // R7: readback shows second rank, not the freshly written first rank
      cur_req = "R7";
      do_read(2, MID, "R7");

      // R4: simultaneous transfer
      cur_req = "R4";
      do_update(1'b0);
      chk_codes("R4", 12'h123, 12'h456, 12'h789, 12'hABC);

      // R3: deselected write ignored
      cur_req = "R3";
      do_write(1'b1, 1, 12'h111, 1'b0);
      do_update(1'b0);
      chk("R3", "ch1 after deselected write", dac_code[1*DW +: DW], 12'h456);

      // R6: deselected update ignored
      cur_req = "R6";
      do_write(1'b0, 3, 12'h321, 1'b0);
      do_update(1'b1);
      chk("R6", "ch3 after deselected update", dac_code[3*DW +: DW], 12'hABC);
      do_update(1'b0);
      chk("R6", "ch3 after selected update", dac_code[3*DW +: DW], 12'h321);

      // R5: transparent second rank while update is held high
      cur_req = "R5";
      @(negedge clk);
      sel_n = 1'b0; upd = 1'b1;
      wait_neg(3);
      do_write(1'b0, 0, 12'h0F0, 1'b1);
      chk("R5", "ch0 follows write in transparent mode", dac_code[0*DW +: DW], 12'h0F0);
      do_write(1'b0, 2, 12'h00F, 1'b1);
      chk("R5", "ch2 follows write in transparent mode", dac_code[2*DW +: DW], 12'h00F);
      @(negedge clk);
      upd = 1'b0;
      wait_neg(3);
      sel_n = 1'b1;
      wait_neg(3);

      // R7: readback of every channel
      cur_req = "R7";
      do_read(0, 12'h0F0, "R7");
      do_read(1, 12'h456, "R7");
      do_read(2, 12'h00F, "R7");
      do_read(3, 12'h321, "R7");

      // R8: read strobe with select high leaves bus released
      cur_req = "R8";
      @(negedge clk);
      sel_n = 1'b1; addr = 2'd1; rd_n = 1'b0;
      wait_neg(4);
      chk("R8", "bus with read and select high", data_io, IDLE);
      rd_n = 1'b1;
      wait_neg(2);

      // R10: bus drive and release latency
      cur_req = "R10";
      @(negedge clk);
      sel_n = 1'b0; addr = 2'd3; rd_n = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk("R10", "bus driven by second edge", data_io, 12'h321);
      @(negedge clk);
      rd_n = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R10", "bus released by second edge", data_io, IDLE);
      @(negedge clk);
      sel_n = 1'b1;
      wait_neg(3);

      // R9: asynchronous reset clears both ranks
      cur_req = "R9";
      do_write(1'b0, 1, 12'h777, 1'b0);
      @(posedge clk);
      #3 rst_n = 1'b0;
      #1;
      chk_codes("R9", MID, MID, MID, MID);
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      do_update(1'b0);
      chk_codes("R9", MID, MID, MID, MID);
      do_read(1, MID, "R9");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule